// File: doc/BRIEF.md
# Command-Driven Page Map with Page Transfer

This block keeps one translation entry per physical memory page. Each entry holds a virtual page tag and two flags: valid and dirty. A processor drives the block through a small command port at negative I/O addresses. A command write can do one of four things: fill a memory page from disk and bind it to a tag, write a memory page back to disk, drop an entry's valid flag, or drop its dirty flag. A command read returns one flag of one page. A second port translates ordinary accesses. It compares the upper address bits with every valid tag at once, reports a hit with the physical page or a fault, and marks the page dirty on a store hit.

Page transfers run in a small state machine. The states are `XF_IDLE`, `XF_LD_PRIME`, `XF_LD_COPY`, `XF_ST_PRIME` and `XF_ST_COPY`. The transitions are:
- `XF_IDLE` to `XF_LD_PRIME` on an accepted load command.
- `XF_IDLE` to `XF_ST_PRIME` on an accepted write-back command.
- Each PRIME state to its COPY state after one cycle.
- Each COPY state back to `XF_IDLE` after the last word.

A PRIME state issues the first read of the source page. Each COPY cycle writes one word to the destination and requests the next source word. Memory and disk are plain synchronous RAMs outside the block, each with one port and a read latency of one cycle.

Top module: `page_map_unit`

## Requirements
- R1: After reset every entry is invalid and clean, and `busy` is low.
- R2: The command data word is decoded as follows. Bits [3:0] give the memory page. The low six bits of field [11:4] give the disk page. Bits [23:12] give the virtual tag. For example, 0x0000E127 names memory page 7, disk page 18 and tag 0x00E.
- R3: A write to address -1 (low byte 0xFF) copies the 16 words of the disk page into the memory page. When the copy ends, the entry takes the tag and becomes valid and clean.
- R4: A write to address -2 (0xFE) copies the 16 words of the memory page to the disk page. When the copy ends, that entry's dirty flag is cleared.
- R5: A write to address -3 (0xFD) clears the valid flag of the page in bits [3:0]. A write to address -4 (0xFC) clears its dirty flag.
- R6: A read of address -(16·P+1) returns page P's valid flag in bit 0. A read of -(16·P+2) returns its dirty flag in bit 0. All other bits read as zero.
- R7: When `lk_req` is high, `lk_hit` is high if some valid tag equals `lk_vaddr[15:4]`. `lk_ppage` then gives the lowest matching page. `lk_fault` is high exactly when no tag matches.
- R8: A store lookup that hits sets that entry's dirty flag one cycle later. If a dirty-clear command for the same page arrives in the same cycle, the command wins.
- R9: An accepted copy command raises `busy` in the next cycle. `busy` then stays high for exactly 17 cycles (one prime cycle and 16 word cycles). Command writes arriving while `busy` is high are ignored.
- R10: Lookups keep working during a copy. The target page of a load loses its valid flag in the cycle after the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_rd | input | 1 | Command read strobe |
| cmd_addr | input | 8 | Low byte of the negative I/O address |
| cmd_wdata | input | 24 | Packed command word |
| cmd_rdata | output | 32 | Status read data |
| busy | output | 1 | A page copy is in progress |
| lk_req | input | 1 | Lookup request |
| lk_store | input | 1 | The lookup is a store |
| lk_vaddr | input | 16 | Virtual word address |
| lk_hit | output | 1 | Lookup hit |
| lk_fault | output | 1 | Lookup miss |
| lk_ppage | output | 4 | Physical page of the hit |
| mem_addr | output | 8 | Memory word address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the address |
| dsk_addr | output | 10 | Disk word address |
| dsk_we | output | 1 | Disk write enable |
| dsk_wdata | output | 32 | Disk write data |
| dsk_rdata | input | 32 | Disk read data, one cycle after the address |

## Verification
The bench uses the default parameters: 16 pages of 16 words, a 64-page disk, 12-bit tags and 32-bit words. With 16 entries, every page's status can be read back after each operation. With 64 disk pages, random transfers reach every disk slot, including the example command.

Random tags are drawn from only eight values, so several entries often share a tag. This exercises the lowest-index priority of R7. Directed cases cover three races: a command during a copy, a lookup on the page being loaded, and a store hit colliding with a dirty clear.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    // Copy engine states
    typedef enum logic [2:0] {
        XF_IDLE,
        XF_LD_PRIME,
        XF_LD_COPY,
        XF_ST_PRIME,
        XF_ST_COPY
    } xf_state_t;

    // Field offsets inside the packed command word
    localparam int FLD_DISK_LO = 4;
    localparam int FLD_DISK_W  = 8;
    localparam int FLD_TAG_LO  = 12;

endpackage

// File: rtl/pmu_tag_array.sv
module pmu_tag_array #(
    parameter int NUM_PAGES = 16,
    parameter int VTAG_W    = 12,
    parameter int PG_BITS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               lk_req,
    input  logic               lk_store,
    input  logic [VTAG_W-1:0]  lk_tag,
    input  logic               fill_en,
    input  logic [PG_BITS-1:0] fill_idx,
    input  logic [VTAG_W-1:0]  fill_tag,
    input  logic               inval_en,
    input  logic [PG_BITS-1:0] inval_idx,
    input  logic               clean_en,
    input  logic [PG_BITS-1:0] clean_idx,
    output logic               hit_any,
    output logic [PG_BITS-1:0] hit_idx,
    output logic [NUM_PAGES-1:0] valid_vec,
    output logic [NUM_PAGES-1:0] dirty_vec
);

    logic [VTAG_W-1:0]    tag_q [NUM_PAGES];
    logic [NUM_PAGES-1:0] valid_q;
    logic [NUM_PAGES-1:0] dirty_q;
    logic [NUM_PAGES-1:0] match;
    logic                 set_dirty;

    // One comparator per entry
    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (tag_q[g] == lk_tag);
    end

    // Lowest matching index wins
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_PAGES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = PG_BITS'(i);
        end
    end

    assign hit_any   = |match;
    assign set_dirty = lk_req && lk_store && hit_any;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < NUM_PAGES; i++) tag_q[i] <= '0;
        end else begin
            for (int i = 0; i < NUM_PAGES; i++) begin
                if (set_dirty && hit_idx == PG_BITS'(i)) dirty_q[i] <= 1'b1;
                // a command clear comes later, so it wins over a store hit
                if (clean_en && clean_idx == PG_BITS'(i)) dirty_q[i] <= 1'b0;
                if (inval_en && inval_idx == PG_BITS'(i)) valid_q[i] <= 1'b0;
                if (fill_en && fill_idx == PG_BITS'(i)) begin
                    tag_q[i]   <= fill_tag;
                    valid_q[i] <= 1'b1;
                    dirty_q[i] <= 1'b0;
                end
            end
        end
    end

    assign valid_vec = valid_q;
    assign dirty_vec = dirty_q;

endmodule

// File: rtl/pmu_xfer.sv
module pmu_xfer
    import pmu_pkg::*;
#(
    parameter int PG_BITS    = 4,
    parameter int OFF_BITS   = 4,
    parameter int DPG_BITS   = 6,
    parameter int VTAG_W     = 12,
    parameter int PAGE_WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_load,
    input  logic                         start_store,
    input  logic [PG_BITS-1:0]           req_mpg,
    input  logic [DPG_BITS-1:0]          req_dpg,
    input  logic [VTAG_W-1:0]            req_tag,
    output logic                         busy,
    output logic [PG_BITS+OFF_BITS-1:0]  mem_addr,
    output logic                         mem_we,
    output logic [DPG_BITS+OFF_BITS-1:0] dsk_addr,
    output logic                         dsk_we,
    output logic                         fill_en,
    output logic [PG_BITS-1:0]           fill_idx,
    output logic [VTAG_W-1:0]            fill_tag,
    output logic                         clean_en,
    output logic [PG_BITS-1:0]           clean_idx
);

    localparam logic [OFF_BITS-1:0] LAST_OFF = OFF_BITS'(PAGE_WORDS - 1);

    xf_state_t             state;
    logic [OFF_BITS-1:0]   cnt;
    logic [OFF_BITS-1:0]   nxt_off;
    logic [PG_BITS-1:0]    mpg_q;
    logic [DPG_BITS-1:0]   dpg_q;
    logic [VTAG_W-1:0]     tag_q;
    logic                  last;

    assign last    = (cnt == LAST_OFF);
    assign nxt_off = cnt + OFF_BITS'(1);

    // State register, word counter and latched command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= XF_IDLE;
            cnt   <= '0;
            mpg_q <= '0;
            dpg_q <= '0;
            tag_q <= '0;
        end else begin
            unique case (state)
                XF_IDLE: begin
                    cnt <= '0;
                    if (start_load || start_store) begin
                        mpg_q <= req_mpg;
                        dpg_q <= req_dpg;
                        tag_q <= req_tag;
                        state <= start_load ? XF_LD_PRIME : XF_ST_PRIME;
                    end
                end
                XF_LD_PRIME: state <= XF_LD_COPY;
                XF_ST_PRIME: state <= XF_ST_COPY;
                XF_LD_COPY, XF_ST_COPY: begin
                    if (last) state <= XF_IDLE;
                    else      cnt   <= nxt_off;
                end
                default: state <= XF_IDLE;
            endcase
        end
    end

    // Port addresses, strobes and completion pulses
    always_comb begin
        busy      = 1'b1;
        mem_addr  = '0;
        mem_we    = 1'b0;
        dsk_addr  = '0;
        dsk_we    = 1'b0;
        fill_en   = 1'b0;
        clean_en  = 1'b0;
        fill_idx  = mpg_q;
        fill_tag  = tag_q;
        clean_idx = mpg_q;
        unique case (state)
            XF_IDLE: busy = 1'b0;
            XF_LD_PRIME: dsk_addr = {dpg_q, {OFF_BITS{1'b0}}};
            XF_LD_COPY: begin
                dsk_addr = {dpg_q, nxt_off};
                mem_addr = {mpg_q, cnt};
                mem_we   = 1'b1;
                fill_en  = last;
            end
            XF_ST_PRIME: mem_addr = {mpg_q, {OFF_BITS{1'b0}}};
            XF_ST_COPY: begin
                mem_addr = {mpg_q, nxt_off};
                dsk_addr = {dpg_q, cnt};
                dsk_we   = 1'b1;
                clean_en = last;
            end
            default: busy = 1'b0;
        endcase
    end

endmodule

// File: rtl/page_map_unit.sv
module page_map_unit
    import pmu_pkg::*;
#(
    parameter int NUM_PAGES  = 16,
    parameter int PAGE_WORDS = 16,
    parameter int DISK_PAGES = 64,
    parameter int VTAG_W     = 12,
    parameter int WORD_W     = 32,
    parameter int CMD_AW     = 8
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cmd_wr,
    input  logic                                          cmd_rd,
    input  logic [CMD_AW-1:0]                             cmd_addr,
    input  logic [FLD_TAG_LO+VTAG_W-1:0]                  cmd_wdata,
    output logic [WORD_W-1:0]                             cmd_rdata,
    output logic                                          busy,
    input  logic                                          lk_req,
    input  logic                                          lk_store,
    input  logic [VTAG_W+$clog2(PAGE_WORDS)-1:0]          lk_vaddr,
    output logic                                          lk_hit,
    output logic                                          lk_fault,
    output logic [$clog2(NUM_PAGES)-1:0]                  lk_ppage,
    output logic [$clog2(NUM_PAGES)+$clog2(PAGE_WORDS)-1:0]  mem_addr,
    output logic                                          mem_we,
    output logic [WORD_W-1:0]                             mem_wdata,
    input  logic [WORD_W-1:0]                             mem_rdata,
    output logic [$clog2(DISK_PAGES)+$clog2(PAGE_WORDS)-1:0] dsk_addr,
    output logic                                          dsk_we,
    output logic [WORD_W-1:0]                             dsk_wdata,
    input  logic [WORD_W-1:0]                             dsk_rdata
);

    localparam int PG_BITS  = $clog2(NUM_PAGES);
    localparam int OFF_BITS = $clog2(PAGE_WORDS);
    localparam int DPG_BITS = $clog2(DISK_PAGES);
    localparam logic [CMD_AW-1:0] A_LOAD  = '1;
    localparam logic [CMD_AW-1:0] A_STORE = A_LOAD - CMD_AW'(1);
    localparam logic [CMD_AW-1:0] A_INVAL = A_LOAD - CMD_AW'(2);
    localparam logic [CMD_AW-1:0] A_CLEAN = A_LOAD - CMD_AW'(3);

    logic [PG_BITS-1:0]   f_mpg;
    logic [DPG_BITS-1:0]  f_dpg;
    logic [VTAG_W-1:0]    f_tag;
    logic                 accept;
    logic                 go_load, go_store, do_inval, do_clean;
    logic [CMD_AW-1:0]    neg_addr;
    logic [PG_BITS-1:0]   rd_pg;
    logic [3:0]           rd_kind;
    logic                 rd_bit;
    logic                 hit_any;
    logic [NUM_PAGES-1:0] valid_vec, dirty_vec;
    logic                 x_fill_en, x_clean_en, clean_en, inval_en;
    logic [PG_BITS-1:0]   x_fill_idx, x_clean_idx, clean_idx;
    logic [VTAG_W-1:0]    x_fill_tag;
    logic                 unused_bits;

    // Command field split
    assign f_mpg = cmd_wdata[PG_BITS-1:0];
    assign f_dpg = cmd_wdata[FLD_DISK_LO +: DPG_BITS];
    assign f_tag = cmd_wdata[FLD_TAG_LO +: VTAG_W];
    assign unused_bits = ^{cmd_wdata[FLD_DISK_LO+DPG_BITS +: FLD_DISK_W-DPG_BITS],
                           cmd_wdata[FLD_DISK_LO-1:PG_BITS], lk_vaddr[OFF_BITS-1:0]};

    // Write decode; writes during a copy are dropped
    assign accept   = cmd_wr && !busy;
    assign go_load  = accept && (cmd_addr == A_LOAD);
    assign go_store = accept && (cmd_addr == A_STORE);
    assign do_inval = accept && (cmd_addr == A_INVAL);
    assign do_clean = accept && (cmd_addr == A_CLEAN);

    // Read decode: negate the address, then page nibble and selector nibble
    assign neg_addr = CMD_AW'(0) - cmd_addr;
    assign rd_pg    = neg_addr[4 +: PG_BITS];
    assign rd_kind  = neg_addr[3:0];
    always_comb begin
        unique case (rd_kind)
            4'd1:    rd_bit = valid_vec[rd_pg];
            4'd2:    rd_bit = dirty_vec[rd_pg];
            default: rd_bit = 1'b0;
        endcase
    end
    assign cmd_rdata = WORD_W'(cmd_rd && rd_bit);

    pmu_xfer #(
        .PG_BITS(PG_BITS), .OFF_BITS(OFF_BITS), .DPG_BITS(DPG_BITS),
        .VTAG_W(VTAG_W), .PAGE_WORDS(PAGE_WORDS)
    ) i_xfer (
        .clk(clk), .rst_n(rst_n),
        .start_load(go_load), .start_store(go_store),
        .req_mpg(f_mpg), .req_dpg(f_dpg), .req_tag(f_tag),
        .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we),
        .dsk_addr(dsk_addr), .dsk_we(dsk_we),
        .fill_en(x_fill_en), .fill_idx(x_fill_idx), .fill_tag(x_fill_tag),
        .clean_en(x_clean_en), .clean_idx(x_clean_idx)
    );

    // The two clean sources never coincide: commands are dropped while busy
    assign clean_en  = x_clean_en || do_clean;
    assign clean_idx = x_clean_en ? x_clean_idx : f_mpg;
    assign inval_en  = do_inval || go_load;

    pmu_tag_array #(
        .NUM_PAGES(NUM_PAGES), .VTAG_W(VTAG_W), .PG_BITS(PG_BITS)
    ) i_tags (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_store(lk_store),
        .lk_tag(lk_vaddr[OFF_BITS +: VTAG_W]),
        .fill_en(x_fill_en), .fill_idx(x_fill_idx), .fill_tag(x_fill_tag),
        .inval_en(inval_en), .inval_idx(f_mpg),
        .clean_en(clean_en), .clean_idx(clean_idx),
        .hit_any(hit_any), .hit_idx(lk_ppage),
        .valid_vec(valid_vec), .dirty_vec(dirty_vec)
    );

    assign lk_hit    = lk_req && hit_any;
    assign lk_fault  = lk_req && !hit_any;
    assign mem_wdata = dsk_rdata;
    assign dsk_wdata = mem_rdata;

endmodule

// File: rtl/pmu_checker.sv
module pmu_checker #(
    parameter int NUM_PAGES  = 16,
    parameter int PAGE_WORDS = 16,
    parameter int PG_BITS    = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 busy,
    input logic                 cmd_wr,
    input logic                 lk_req,
    input logic                 lk_store,
    input logic                 lk_hit,
    input logic                 lk_fault,
    input logic [PG_BITS-1:0]   lk_ppage,
    input logic                 mem_we,
    input logic                 dsk_we,
    input logic                 clean_en,
    input logic [NUM_PAGES-1:0] dirty_vec
);

    localparam int RUN_MAX = PAGE_WORDS + 1;

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (!rst_n)    busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == RUN_MAX);

    assert_busy_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_MAX);

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_wr));

    assert_hit_xor_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> (lk_hit != lk_fault));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_fault));

    assert_copy_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || dsk_we) |-> busy && !(mem_we && dsk_we));

    assert_store_dirty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_store && lk_hit && !clean_en) |=> dirty_vec[$past(lk_ppage)]);

endmodule

bind page_map_unit pmu_checker #(
    .NUM_PAGES(NUM_PAGES), .PAGE_WORDS(PAGE_WORDS), .PG_BITS($clog2(NUM_PAGES))
) i_pmu_checker (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_wr(cmd_wr),
    .lk_req(lk_req), .lk_store(lk_store), .lk_hit(lk_hit), .lk_fault(lk_fault),
    .lk_ppage(lk_ppage), .mem_we(mem_we), .dsk_we(dsk_we),
    .clean_en(clean_en), .dirty_vec(dirty_vec)
);

// File: tb/test_page_map_unit.sv
module test_page_map_unit;

    localparam int NP  = 16;
    localparam int PW  = 16;
    localparam int NDP = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0, cmd_rd = 1'b0;
    logic [7:0]  cmd_addr = '0;
    logic [23:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic        busy;
    logic        lk_req = 1'b0, lk_store = 1'b0;
    logic [15:0] lk_vaddr = '0;
    logic        lk_hit, lk_fault;
    logic [3:0]  lk_ppage;
    logic [7:0]  mem_addr;
    logic        mem_we;
    logic [31:0] mem_wdata, mem_rdata;
    logic [9:0]  dsk_addr;
    logic        dsk_we;
    logic [31:0] dsk_wdata, dsk_rdata;

    logic        tb_mwe = 1'b0;
    logic [7:0]  tb_maddr = '0;
    logic [31:0] tb_mdata = '0;

    logic [31:0] mram [NP*PW];
    logic [31:0] dram [NDP*PW];
    logic [31:0] exp_mem [NP*PW];
    logic [31:0] exp_dsk [NDP*PW];
    logic        ev [NP];
    logic        ed [NP];
    logic [11:0] et [NP];

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    function automatic logic [31:0] f_dsk(int i);
        return (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
    endfunction
    function automatic logic [31:0] f_mem(int i);
        return ~32'(i);
    endfunction

    // External memory and disk: one port each, read latency of one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP*PW; i++) mram[i] <= f_mem(i);
        end else if (mem_we) begin
            mram[mem_addr] <= mem_wdata;
        end else if (tb_mwe) begin
            mram[tb_maddr] <= tb_mdata;
        end
        mem_rdata <= mram[mem_addr];
    end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDP*PW; i++) dram[i] <= f_dsk(i);
        end else if (dsk_we) begin
            dram[dsk_addr] <= dsk_wdata;
        end
        dsk_rdata <= dram[dsk_addr];
    end

    page_map_unit i_page_map_unit (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(cmd_wr), .cmd_rd(cmd_rd), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .busy(busy),
        .lk_req(lk_req), .lk_store(lk_store), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_ppage(lk_ppage),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dsk_addr(dsk_addr), .dsk_we(dsk_we), .dsk_wdata(dsk_wdata), .dsk_rdata(dsk_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] mk_cmd(int m, int d, logic [11:0] t);
        return {t, 2'b00, 6'(d), 4'(m)};
    endfunction

    task automatic t_cmd(input logic [7:0] a, input logic [23:0] d);
        @(negedge clk);
        cmd_addr = a; cmd_wdata = d; cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic t_wait();
        while (busy) @(negedge clk);
    endtask

    task automatic t_rd(input int p, input int k, output logic [31:0] v);
        cmd_addr = 8'(9'h100 - 9'(p*16 + k));
        cmd_rd = 1'b1;
        #1;
        v = cmd_rdata;
        cmd_rd = 1'b0;
    endtask

    // R6: status of every page against the model
    task automatic t_status(input string req);
        logic [31:0] v;
        for (int p = 0; p < NP; p++) begin
            t_rd(p, 1, v);
            check(v == 32'(ev[p]), {req, " valid (R6)"}, v, 32'(ev[p]));
            t_rd(p, 2, v);
            check(v == 32'(ed[p]), {req, " dirty (R6)"}, v, 32'(ed[p]));
        end
    endtask

    task automatic t_look(input logic [11:0] tag, input bit st, input string req);
        int  idx = -1;
        for (int p = NP - 1; p >= 0; p--) if (ev[p] && et[p] == tag) idx = p;
        lk_vaddr = {tag, 4'($urandom % 16)};
        lk_store = st;
        lk_req = 1'b1;
        #1;
        check(lk_hit == (idx >= 0), {req, " hit (R7)"}, 32'(lk_hit), 32'(idx >= 0));
        check(lk_fault == (idx < 0), {req, " fault (R7)"}, 32'(lk_fault), 32'(idx < 0));
        if (idx >= 0)
            check(lk_ppage == 4'(idx), {req, " ppage (R7)"}, 32'(lk_ppage), 32'(idx));
        if (st) begin
            @(negedge clk);
            if (idx >= 0) ed[idx] = 1'b1;
        end
        lk_req = 1'b0;
        lk_store = 1'b0;
    endtask

    task automatic m_load(int m, int d, logic [11:0] t);
        ev[m] = 1'b1; ed[m] = 1'b0; et[m] = t;
        for (int w = 0; w < PW; w++) exp_mem[m*PW+w] = exp_dsk[d*PW+w];
    endtask

    task automatic t_chk_mem(int m, input string req);
        for (int w = 0; w < PW; w++)
            check(mram[m*PW+w] == exp_mem[m*PW+w], req, mram[m*PW+w], exp_mem[m*PW+w]);
    endtask

    task automatic t_chk_dsk(int d, input string req);
        for (int w = 0; w < PW; w++)
            check(dram[d*PW+w] == exp_dsk[d*PW+w], req, dram[d*PW+w], exp_dsk[d*PW+w]);
    endtask

    task automatic t_scribble(int m);
        for (int w = 0; w < PW; w++) begin
            @(negedge clk);
            tb_mwe = 1'b1; tb_maddr = 8'(m*PW+w); tb_mdata = $urandom;
            exp_mem[m*PW+w] = tb_mdata;
        end
        @(negedge clk);
        tb_mwe = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd4242));
        for (int i = 0; i < NP*PW; i++) exp_mem[i] = f_mem(i);
        for (int i = 0; i < NDP*PW; i++) exp_dsk[i] = f_dsk(i);
        for (int p = 0; p < NP; p++) begin ev[p] = 0; ed[p] = 0; et[p] = '0; end

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
        t_status("R1 reset");
        t_look(12'h00E, 1'b0, "R1 empty lookup");

        // R2/R3: example command, busy length (R9)
        t_cmd(8'hFF, 24'h00E127);
        n = 0;
        while (busy && n < 100) begin n++; @(negedge clk); end
        check(n == 17, "R9 busy length", 32'(n), 17);
        m_load(7, 18, 12'h00E);
        t_chk_mem(7, "R3 load data page 7");
        t_status("R3 after load");
        t_look(12'h00E, 1'b0, "R2 example tag");

        // R8: store hit marks dirty
        t_look(12'h00E, 1'b1, "R8 store hit");
        t_rd(7, 2, v);
        check(v == 1, "R8 dirty after store", v, 1);

        // R4: write-back
        t_scribble(7);
        t_cmd(8'hFE, 24'h00E127);
        t_wait();
        for (int w = 0; w < PW; w++) exp_dsk[18*PW+w] = exp_mem[7*PW+w];
        ed[7] = 1'b0;
        t_chk_dsk(18, "R4 write-back disk page 18");
        t_status("R4 after write-back");

        // R5: dirty clear
        t_look(12'h00E, 1'b1, "R5 setup");
        t_cmd(8'hFC, 24'h000007);
        ed[7] = 1'b0;
        t_status("R5 after dirty clear");

        // R8: same-cycle store hit and dirty clear
        @(negedge clk);
        lk_vaddr = 16'h00E3; lk_store = 1'b1; lk_req = 1'b1;
        cmd_addr = 8'hFC; cmd_wdata = 24'h000007; cmd_wr = 1'b1;
        @(negedge clk);
        lk_req = 1'b0; lk_store = 1'b0; cmd_wr = 1'b0;
        t_rd(7, 2, v);
        check(v == 0, "R8 clear wins over store hit", v, 0);

        // R10/R9: lookups during copy, commands ignored while busy
        t_cmd(8'hFF, mk_cmd(3, 2, 12'h005));
        t_wait();
        m_load(3, 2, 12'h005);
        t_cmd(8'hFF, mk_cmd(3, 3, 12'h009));
        ev[3] = 1'b0;
        t_look(12'h005, 1'b0, "R10 target dropped during copy");
        t_look(12'h00E, 1'b0, "R10 other page during copy");
        t_cmd(8'hFD, 24'h000007);
        check(busy == 1'b1, "R9 still busy", 32'(busy), 1);
        t_wait();
        m_load(3, 3, 12'h009);
        t_chk_mem(3, "R3 second load page 3");
        t_status("R9 ignored command");

        // R5: valid clear
        t_cmd(8'hFD, 24'h000007);
        ev[7] = 1'b0;
        t_look(12'h00E, 1'b0, "R5 after valid clear");
        t_status("R5 after valid clear");

        // R7: duplicate tags, lowest page wins
        t_cmd(8'hFF, mk_cmd(9, 40, 12'h077)); t_wait(); m_load(9, 40, 12'h077);
        t_cmd(8'hFF, mk_cmd(2, 63, 12'h077)); t_wait(); m_load(2, 63, 12'h077);
        t_look(12'h077, 1'b0, "R7 priority");

        // Random mix
        for (int it = 0; it < 60; it++) begin
            int op = $urandom % 5;
            int m  = $urandom % NP;
            int d  = $urandom % NDP;
            logic [11:0] t = 12'($urandom % 8);
            case (op)
                0: begin
                    t_cmd(8'hFF, mk_cmd(m, d, t)); t_wait(); m_load(m, d, t);
                    t_chk_mem(m, "R3 random load");
                end
                1: begin
                    t_scribble(m);
                    t_cmd(8'hFE, mk_cmd(m, d, t)); t_wait();
                    for (int w = 0; w < PW; w++) exp_dsk[d*PW+w] = exp_mem[m*PW+w];
                    ed[m] = 1'b0;
                    t_chk_dsk(d, "R4 random write-back");
                end
                2: begin t_cmd(8'hFD, mk_cmd(m, d, t)); ev[m] = 1'b0; end
                3: begin t_cmd(8'hFC, mk_cmd(m, d, t)); ed[m] = 1'b0; end
                default: t_look(t, 1'b1, "R8 random store lookup");
            endcase
            t_look(12'($urandom % 8), 1'b0, "R7 random lookup");
            t_status("R6 random status");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule